// File: doc/BRIEF.md
# Inter-Core Message Interrupt Mailbox

This block lets any core of a multi-core system post a short message to any other core and raise an interrupt there. Each core has a pair of 32-bit registers on a shared register bus. The control register is write-only. One write to it can send a message, made of a target core number and a 16-bit payload, and it can also acknowledge the writer's own pending message. The status register is read-only. It shows whether a message is waiting, which core sent it and the payload that came with it.

Each core gets one level-sensitive interrupt line. The line stays high while that core has a message it has not acknowledged. The block has no interrupt inputs, so messages arrive only through bus writes. The bus is word-wide and big-endian: bus lane 0, which is `bus_wdata[7:0]` and `bus_rdata[7:0]`, carries register bits 31:24. The number of cores is a parameter from 2 to 16.

Top module: `ipi_mailbox`

## Requirements
- R1: Core c's control register is at byte address 8·c and its status register is at 8·c+4. A write to an address whose bits 1:0 are not zero, or whose core number is at or above NUM_CORES, has no effect. A read of such an address returns zero.
- R2: Register bits 31:24, 23:16, 15:8 and 7:0 travel on bus bits 7:0, 15:8, 23:16 and 31:24 respectively, for both writes and reads.
- R3: A control write by core S with bit 30 (generate) set and a destination D in bits 29:16 below NUM_CORES sets D's pending flag. It also records S as the source and bits 15:0 as the payload, and raises `irq_out[D]` from the cycle after the write. A write with bit 30 clear delivers nothing.
- R4: The status word reads as {bit 31 = 0, bit 30 = pending, bits 29:16 = source core, bits 15:0 = payload}. A control register always reads zero. Writes to a status address are ignored.
- R5: `irq_out[c]` is high exactly while core c's pending flag is set, and it changes only after a bus write.
- R6: A control write by core c with bit 31 (acknowledge) set clears c's own pending flag and keeps its source and payload fields. It leaves the other cores untouched and has no effect when nothing is pending.
- R7: A generate whose destination is at or above NUM_CORES changes no pending flag and no status field.
- R8: A message to a core that is already pending overwrites the source and payload, and the flag stays set.
- R9: When acknowledge and generate come in the same write, the acknowledge clears the writer's flag and the message is still delivered. If the writer names itself as the destination, the delivery wins and the flag stays set with the new fields.
- R10: Reset clears every pending flag, every status field, all interrupt lines and the read data.
- R11: `bus_rdata` is updated one cycle after a cycle with `bus_rd` high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data, lane 0 in bits 7:0 |
| bus_rdata | output | 32 | Read data, lane 0 in bits 7:0 |
| irq_out | output | NUM_CORES | Per-core level interrupt |

## Verification
A wrong pending flag shows on `irq_out` at the edge that follows the write, so the bench compares the interrupt vector after every write. A corrupted source or payload field does not show on any line until software reads the status word. For that reason the bench reads back every status register after each scenario, and a bad field appears in `bus_rdata` one cycle after the read strobe. Byte-lane mistakes appear at once, because the bench builds the bus words independently of the design, so a wrong lane order misroutes the generate and destination bits.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    localparam int REG_W  = 32;
    localparam int DATA_W = 16;
    localparam int ID_W   = 14;

    typedef struct packed {
        logic              ack;
        logic              gen;
        logic [ID_W-1:0]   dst;
        logic [DATA_W-1:0] data;
    } ctrl_word_t;

    typedef struct packed {
        logic              rsvd;
        logic              pend;
        logic [ID_W-1:0]   src;
        logic [DATA_W-1:0] data;
    } stat_word_t;

    typedef struct packed {
        logic              valid;
        logic [ID_W-1:0]   dst;
        logic [ID_W-1:0]   src;
        logic [DATA_W-1:0] data;
    } deliver_t;

    // bus lane 0 (bits 7:0) <-> register bits 31:24; self-inverse
    function automatic logic [REG_W-1:0] lane_swap(input logic [REG_W-1:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
    import ipi_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 8
) (
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [REG_W-1:0]     bus_wdata,
    output logic [NUM_CORES-1:0] ack_vec,
    output deliver_t             deliv
);
    localparam int IDX_W = ADDR_W - 3;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_CORES - 1);
    localparam logic [ID_W-1:0]  DST_LAST = ID_W'(NUM_CORES - 1);

    ctrl_word_t       cw;
    logic [IDX_W-1:0] idx;
    logic             wr_ctrl;

    always_comb begin
        cw      = ctrl_word_t'(lane_swap(bus_wdata));
        idx     = bus_addr[ADDR_W-1:3];
        wr_ctrl = bus_wr && (bus_addr[1:0] == 2'b00) && !bus_addr[2] && (idx <= IDX_LAST);

        for (int i = 0; i < NUM_CORES; i++) begin
            ack_vec[i] = wr_ctrl && cw.ack && (idx == IDX_W'(i));
        end

        deliv.valid = wr_ctrl && cw.gen && (cw.dst <= DST_LAST);
        deliv.dst   = cw.dst;
        deliv.src   = ID_W'(idx);
        deliv.data  = cw.data;
    end
endmodule

// File: rtl/ipi_slot.sv
module ipi_slot
    import ipi_pkg::*;
#(
    parameter int SLOT_ID = 0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ack,
    input  deliver_t   deliv,
    output stat_word_t stat
);
    logic hit;
    assign hit = deliv.valid && (deliv.dst == ID_W'(SLOT_ID));

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
        end else if (hit) begin
            // delivery outranks a same-cycle self acknowledge
            stat.rsvd <= 1'b0;
            stat.pend <= 1'b1;
            stat.src  <= deliv.src;
            stat.data <= deliv.data;
        end else if (ack) begin
            stat.pend <= 1'b0;
        end
    end
endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox
    import ipi_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [NUM_CORES-1:0] irq_out
);
    localparam int IDX_W = ADDR_W - 3;
    localparam int CW    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_CORES - 1);

    logic [NUM_CORES-1:0] ack_vec;
    deliver_t             deliv;
    stat_word_t           stat [NUM_CORES];

    ipi_decode #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_decode (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .ack_vec   (ack_vec),
        .deliv     (deliv)
    );

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_slot
        ipi_slot #(.SLOT_ID(g)) u_slot (
            .clk   (clk),
            .rst   (rst),
            .ack   (ack_vec[g]),
            .deliv (deliv),
            .stat  (stat[g])
        );
        assign irq_out[g] = stat[g].pend;
    end

    logic [IDX_W-1:0] rd_idx;
    logic             rd_stat;
    logic [REG_W-1:0] rd_word;

    always_comb begin
        rd_idx  = bus_addr[ADDR_W-1:3];
        rd_stat = (bus_addr[1:0] == 2'b00) && bus_addr[2] && (rd_idx <= IDX_LAST);
        rd_word = rd_stat ? REG_W'(stat[rd_idx[CW-1:0]]) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= lane_swap(rd_word);
        end
    end
endmodule

// File: rtl/ipi_mailbox_chk.sv
module ipi_mailbox_chk #(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_wr,
    input logic                 bus_rd,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [15:0]          ctl_lanes,
    input logic [31:0]          bus_rdata,
    input logic [NUM_CORES-1:0] irq_out
);
    localparam int IDX_W = ADDR_W - 3;
    localparam int CW    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_CORES - 1);
    localparam logic [13:0]      DST_LAST = 14'(NUM_CORES - 1);

    logic [15:0]      hi;
    logic [IDX_W-1:0] idx;
    logic             wr_ctrl;
    logic [CW-1:0]    core_sel;
    logic [CW-1:0]    dst_sel;

    assign hi       = {ctl_lanes[7:0], ctl_lanes[15:8]};
    assign idx      = bus_addr[ADDR_W-1:3];
    assign wr_ctrl  = bus_wr && (bus_addr[1:0] == 2'b00) && !bus_addr[2] && (idx <= IDX_LAST);
    assign core_sel = idx[CW-1:0];
    assign dst_sel  = hi[CW-1:0];

    // R10
    rst_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (irq_out == '0 && bus_rdata == '0));

    // R4
    stat_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rdata[7]);

    // R5
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> $stable(irq_out));

    // R3
    one_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(irq_out & ~$past(irq_out)) <= 1);

    // R3
    deliver_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && hi[14] && hi[13:0] <= DST_LAST) |=> irq_out[$past(dst_sel)]);

    // R7
    bad_dst_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && !hi[15] && hi[13:0] > DST_LAST) |=> $stable(irq_out));

    // R6
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && hi[15] && !(hi[14] && hi[13:0] == 14'(idx))) |=> !irq_out[$past(core_sel)]);

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));
endmodule

bind ipi_mailbox ipi_mailbox_chk #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .ctl_lanes (bus_wdata[15:0]),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out)
);

// File: tb/ipi_mailbox_tb.sv
module ipi_mailbox_tb;
    localparam int N = 4;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  irq_out;

    always #2.5 clk = ~clk;

    ipi_mailbox #(.NUM_CORES(N), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    int n_chk = 0;
    int n_bad = 0;

    // reference model
    logic        m_pend [N];
    logic [13:0] m_src  [N];
    logic [15:0] m_dat  [N];
    logic [31:0] last_rd = '0;

    typedef struct {
        logic [31:0] exp;
        string       req;
    } item_t;
    item_t sb_q[$];

    function automatic logic [31:0] swp(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_pend[i] = 1'b0; m_src[i] = '0; m_dat[i] = '0;
        end
        last_rd = '0;
    endtask

    function automatic logic [31:0] model_read(input logic [7:0] a);
        int c;
        c = int'(a[7:3]);
        if (a[1:0] != 2'b00 || !a[2] || c >= N) return 32'h0;
        return {1'b0, m_pend[c], m_src[c], m_dat[c]};
    endfunction

    // driver: one write cycle, model updated alongside
    task automatic wr(input logic [7:0] a, input logic [31:0] r);
        int s;
        int d;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = swp(r);
        s = int'(a[7:3]);
        if (a[1:0] == 2'b00 && !a[2] && s < N) begin
            if (r[31]) m_pend[s] = 1'b0;
            d = int'(r[29:16]);
            if (r[30] && d < N) begin
                m_pend[d] = 1'b1; m_src[d] = 14'(s); m_dat[d] = r[15:0];
            end
        end
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // driver: one read cycle, expected item pushed to the scoreboard
    task automatic rd(input logic [7:0] a, input string req);
        item_t it;
        bus_rd = 1'b1; bus_addr = a;
        it.exp = swp(model_read(a));
        it.req = req;
        last_rd = it.exp;
        sb_q.push_back(it);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk_irq(input string req);
        logic [31:0] e;
        e = '0;
        for (int i = 0; i < N; i++) e[i] = m_pend[i];
        chk(req, 32'(irq_out), e);
    endtask

    task automatic rd_all(input string req);
        for (int c = 0; c < N; c++) rd(8'(c * 8 + 4), req);
    endtask

    function automatic logic [31:0] msg(input bit ack, input bit gen, input int dst, input logic [15:0] d);
        return {ack, gen, 14'(dst), d};
    endfunction

    // monitor: compares read data one cycle after the strobe
    logic rd_seen = 1'b0;
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (sb_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R11 actual=%h expected=<no item>", bus_rdata);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                chk(it.req, bus_rdata, it.exp);
            end
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        chk_irq("R10");
        chk("R10 rdata", bus_rdata, 32'h0);
        rd_all("R10");

        // R3 basic delivery, R2 lane order
        wr(8'h00, msg(0, 1, 2, 16'hBEEF));
        chk_irq("R3");
        rd(8'h14, "R3");
        rd(8'h14, "R2");
        // R4 control reads zero
        rd(8'h10, "R4");
        rd(8'h00, "R4");
        // R3 no generate, no delivery
        wr(8'h08, msg(0, 0, 3, 16'h5555));
        chk_irq("R3 nogen");
        rd_all("R3 nogen");

        // R8 overwrite while pending
        wr(8'h08, msg(0, 1, 2, 16'h1234));
        chk_irq("R8");
        rd(8'h14, "R8");

        // R7 destination out of range
        wr(8'h18, msg(0, 1, 9, 16'hAAAA));
        chk_irq("R7");
        rd_all("R7");

        // R5 level held over idle cycles
        repeat (4) @(negedge clk);
        chk_irq("R5");
        // R11 read data held without strobe
        chk("R11", bus_rdata, last_rd);

        // R6 acknowledge
        wr(8'h10, msg(1, 0, 0, 16'h0));
        chk_irq("R6");
        rd(8'h14, "R6");
        wr(8'h08, msg(1, 0, 0, 16'h0));
        chk_irq("R6 idle ack");
        rd_all("R6 idle ack");

        // R9 ack + generate to another core
        wr(8'h00, msg(0, 1, 1, 16'h0101));
        chk_irq("R9 setup");
        wr(8'h08, msg(1, 1, 3, 16'h3333));
        chk_irq("R9");
        rd_all("R9");
        // R9 ack + generate to itself
        wr(8'h18, msg(1, 1, 3, 16'h7777));
        chk_irq("R9 self");
        rd(8'h1C, "R9 self");

        // R4 status write ignored
        wr(8'h1C, msg(1, 1, 0, 16'hDEAD));
        chk_irq("R4 stat wr");
        rd_all("R4 stat wr");

        // R1 out-of-range core and misaligned addresses
        wr(8'h20, msg(0, 1, 0, 16'hCAFE));
        chk_irq("R1 range");
        wr(8'h01, msg(0, 1, 0, 16'hCAFE));
        chk_irq("R1 align");
        wr(8'h1A, msg(1, 0, 0, 16'h0));
        chk_irq("R1 align ack");
        rd(8'h24, "R1");
        rd(8'h0D, "R1");
        rd_all("R1");

        // R1 each core's window, R3 all destinations
        for (int s = 0; s < N; s++) begin
            wr(8'(s * 8), msg(0, 1, (s + 1) % N, 16'(16'hA000 + s)));
            chk_irq("R1 window");
        end
        rd_all("R1 window");

        // R10 reset mid-run
        @(negedge clk);
        rst = 1'b1;
        model_reset();
        @(negedge clk);
        rst = 1'b0;
        chk_irq("R10 again");
        chk("R10 rdata again", bus_rdata, 32'h0);
        rd_all("R10 again");

        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) begin
            n_chk++; n_bad++;
            $display("FAIL R11 actual=%0d expected=0 pending reads", sb_q.size());
        end
        finish_run();
    end
endmodule